// File: doc/BRIEF.md
# Exclusive Access Monitor for a Memory Slave

This block watches the read-address and write-address channels in front of a memory slave and decides the outcome of exclusive read/write pairs. A locked read that obeys the exclusive rules stores a reservation for its transaction ID. The reservation holds the start address, beat count, beat size, burst type and cache attributes of the read. Each ID has one slot, and a later exclusive read from the same ID overwrites that slot.

A later locked write from the same ID succeeds only when its address and control fields equal the stored reservation and the slot is still live. On success the write gets EXOKAY, goes on to memory and frees the slot. On failure it gets OKAY and its memory write enable is held low. Any write that reaches memory, from any ID, kills every reservation whose byte range it touches.

Each request is presented for one cycle as an address-channel handshake (`ar_fire` / `aw_fire`). The decision appears on registered outputs one clock later. Data channels and the memory itself are outside the block.

Top module: `excl_monitor`

## Requirements
- R1: Reset clears every output to 0 and drops every reservation, so a locked write issued after reset fails.
- R2: A locked read that obeys the exclusive rules returns EXOKAY (code 2'b01). A locked read that breaks a rule returns OKAY (code 2'b00) and records nothing.
- R3: The total byte count, (len+1) shifted left by size, must be a power of two no greater than 128. Examples: 3 bytes is rejected, 128 bytes is accepted, 256 bytes is rejected.
- R4: The request address must be aligned to its total byte count.
- R5: A request whose cache attribute bit 1 is set counts as cacheable and is not valid as an exclusive.
- R6: A locked write that matches a live reservation of its own ID returns EXOKAY and asserts the write enable. Its slot is then free, so an identical second write fails.
- R7: A locked write whose ID has no live slot, or whose address, len, size, burst (INCR=2'b01, FIXED=2'b00) or cache differs from the slot, returns OKAY with the write enable low. Such a write leaves the slot untouched.
- R8: A committed write from any ID that overlaps a reserved byte range, including its last byte, kills that reservation. A write that does not overlap leaves the reservation intact.
- R9: A plain write, or a locked write that breaks a rule, is handled as an ordinary write: the response is OKAY and the write enable is high.
- R10: A new valid exclusive read replaces the earlier reservation of the same ID.
- R11: When a reservation is recorded in the same cycle as a committed write that overlaps it, the new reservation survives.
- R12: A plain read returns OKAY and records no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_fire | input | 1 | Read-address handshake this cycle |
| ar_lock | input | 1 | Read request is exclusive |
| ar_id | input | IDW | Read transaction ID |
| ar_addr | input | AW | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Read log2 bytes per beat |
| ar_burst | input | 2 | Read burst type |
| ar_cache | input | 4 | Read cache attributes |
| aw_fire | input | 1 | Write-address handshake (commit point) this cycle |
| aw_lock | input | 1 | Write request is exclusive |
| aw_id | input | IDW | Write transaction ID |
| aw_addr | input | AW | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | Write log2 bytes per beat |
| aw_burst | input | 2 | Write burst type |
| aw_cache | input | 4 | Write cache attributes |
| rd_resp_valid | output | 1 | Read response code valid |
| rd_resp | output | 2 | Read response code |
| wr_resp_valid | output | 1 | Write response code valid |
| wr_resp | output | 2 | Write response code |
| wr_en | output | 1 | Write allowed to reach memory |

## Verification
Each read and write result is registered once. It is therefore due exactly one clock after the edge that samples the handshake. The bench drives a request on a falling edge and holds it through one rising edge. It then compares the outputs on the next falling edge, before the following request is applied. The reservation table carries state from one vector to the next, so the vector order itself builds each scenario: reserve, disturb, then test the write. The reset case and the same-cycle collision case are directed tests that follow the table.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int IDW = 4,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ar_fire,
  input  logic           ar_lock,
  input  logic [IDW-1:0] ar_id,
  input  logic [AW-1:0]  ar_addr,
  input  logic [7:0]     ar_len,
  input  logic [2:0]     ar_size,
  input  logic [1:0]     ar_burst,
  input  logic [3:0]     ar_cache,
  input  logic           aw_fire,
  input  logic           aw_lock,
  input  logic [IDW-1:0] aw_id,
  input  logic [AW-1:0]  aw_addr,
  input  logic [7:0]     aw_len,
  input  logic [2:0]     aw_size,
  input  logic [1:0]     aw_burst,
  input  logic [3:0]     aw_cache,
  output logic           rd_resp_valid,
  output logic [1:0]     rd_resp,
  output logic           wr_resp_valid,
  output logic [1:0]     wr_resp,
  output logic           wr_en
);
  localparam int NID = 1 << IDW;
  localparam logic [1:0] OKAY = 2'b00;
  localparam logic [1:0] EXOKAY = 2'b01;
  localparam logic [1:0] WRAP = 2'b10;
  localparam logic [1:0] FIXED = 2'b00;

  function automatic logic [15:0] nbytes(input logic [7:0] len, input logic [2:0] size);
    return ({8'd0, len} + 16'd1) << size;
  endfunction

  function automatic logic rules_ok(input logic [7:0] len, input logic [2:0] size,
                                    input logic [6:0] alo, input logic [3:0] cache);
    logic [15:0] b;
    b = nbytes(len, size);
    return ((b & (b - 16'd1)) == 16'd0) && (b <= 16'd128) &&
           ((alo & b[6:0] - 7'd1) == 7'd0) && !cache[1];
  endfunction

  logic          r_vld   [NID];
  logic [AW-1:0] r_addr  [NID];
  logic [AW:0]   r_hi    [NID];
  logic [7:0]    r_len   [NID];
  logic [2:0]    r_size  [NID];
  logic [1:0]    r_burst [NID];
  logic [3:0]    r_cache [NID];

  logic        rd_excl, wr_excl, ex_hit, commit;
  logic [15:0] ar_bytes, aw_bytes, beat_bytes;
  logic [AW:0] w_lo, w_hi;

  assign ar_bytes   = nbytes(ar_len, ar_size);
  assign aw_bytes   = nbytes(aw_len, aw_size);
  assign beat_bytes = 16'd1 << aw_size;
  assign rd_excl    = ar_lock && rules_ok(ar_len, ar_size, ar_addr[6:0], ar_cache);
  assign wr_excl    = aw_lock && rules_ok(aw_len, aw_size, aw_addr[6:0], aw_cache);

  assign ex_hit = r_vld[aw_id] && r_addr[aw_id] == aw_addr && r_len[aw_id] == aw_len &&
                  r_size[aw_id] == aw_size && r_burst[aw_id] == aw_burst &&
                  r_cache[aw_id] == aw_cache;
  assign commit = !wr_excl || ex_hit;

  always_comb begin
    w_lo = {1'b0, aw_addr};
    w_hi = {1'b0, aw_addr} + (AW+1)'(aw_bytes) - 1'b1;
    if (aw_burst == WRAP) begin
      w_lo = {1'b0, aw_addr & ~(AW'(aw_bytes) - 1'b1)};
      w_hi = w_lo + (AW+1)'(aw_bytes) - 1'b1;
    end else if (aw_burst == FIXED) begin
      w_hi = {1'b0, aw_addr} + (AW+1)'(beat_bytes) - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NID; i++) begin
      if (!rst_n) begin
        r_vld[i] <= 1'b0;
      end else if (ar_fire && rd_excl && ar_id == IDW'(i)) begin
        r_vld[i]   <= 1'b1;
        r_addr[i]  <= ar_addr;
        r_hi[i]    <= {1'b0, ar_addr} + (AW+1)'(ar_bytes) - 1'b1;
        r_len[i]   <= ar_len;
        r_size[i]  <= ar_size;
        r_burst[i] <= ar_burst;
        r_cache[i] <= ar_cache;
      end else if (aw_fire && commit && r_vld[i] &&
                   w_lo <= r_hi[i] && {1'b0, r_addr[i]} <= w_hi) begin
        r_vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_resp       <= OKAY;
      wr_resp_valid <= 1'b0;
      wr_resp       <= OKAY;
      wr_en         <= 1'b0;
    end else begin
      rd_resp_valid <= ar_fire;
      rd_resp       <= (ar_fire && rd_excl) ? EXOKAY : OKAY;
      wr_resp_valid <= aw_fire;
      wr_resp       <= (aw_fire && wr_excl && ex_hit) ? EXOKAY : OKAY;
      wr_en         <= aw_fire && commit;
    end
  end

  p_plain_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire && !ar_lock |=> rd_resp_valid && rd_resp == OKAY);
  p_big_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire && ar_size == 3'd7 && ar_len != 8'd0 |=> rd_resp == OKAY);
  p_cacheable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire && ar_cache[1] |=> rd_resp == OKAY);
  p_plain_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire && !aw_lock |=> wr_en && wr_resp == OKAY);
  p_exok_commits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_resp_valid && wr_resp == EXOKAY |-> wr_en);
  p_block_is_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_resp_valid && !wr_en |-> wr_resp == OKAY);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_fire |=> !wr_en && !wr_resp_valid);
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar_fire = 0, ar_lock = 0, aw_fire = 0, aw_lock = 0;
  logic [3:0] ar_id = 0, aw_id = 0;
  logic [31:0] ar_addr = 0, aw_addr = 0;
  logic [7:0] ar_len = 0, aw_len = 0;
  logic [2:0] ar_size = 0, aw_size = 0;
  logic [1:0] ar_burst = 0, aw_burst = 0;
  logic [3:0] ar_cache = 0, aw_cache = 0;
  logic rd_resp_valid, wr_resp_valid, wr_en;
  logic [1:0] rd_resp, wr_resp;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  excl_monitor #(.IDW(4), .AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ar_fire(ar_fire), .ar_lock(ar_lock), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst), .ar_cache(ar_cache),
    .aw_fire(aw_fire), .aw_lock(aw_lock), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst), .aw_cache(aw_cache),
    .rd_resp_valid(rd_resp_valid), .rd_resp(rd_resp),
    .wr_resp_valid(wr_resp_valid), .wr_resp(wr_resp), .wr_en(wr_en));

  typedef struct packed {
    logic        isw;
    logic        lock;
    logic [3:0]  id;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic [3:0]  cache;
    logic [1:0]  resp;
    logic        en;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,4'd1,32'h100,8'd0,3'd2,2'd1,4'd0,2'd1,1'b0,8'd2},  // R2 reserve
    '{1'b1,1'b1,4'd1,32'h100,8'd0,3'd2,2'd1,4'd0,2'd1,1'b1,8'd6},  // R6 success
    '{1'b1,1'b1,4'd1,32'h100,8'd0,3'd2,2'd1,4'd0,2'd0,1'b0,8'd6},  // R6 slot freed
    '{1'b0,1'b1,4'd1,32'h200,8'd3,3'd2,2'd1,4'd0,2'd1,1'b0,8'd2},
    '{1'b1,1'b0,4'd2,32'h300,8'd0,3'd2,2'd1,4'd0,2'd0,1'b1,8'd9},  // R9 plain
    '{1'b1,1'b1,4'd1,32'h200,8'd3,3'd2,2'd1,4'd0,2'd1,1'b1,8'd8},  // R8 no overlap
    '{1'b0,1'b1,4'd1,32'h400,8'd0,3'd3,2'd1,4'd0,2'd1,1'b0,8'd2},
    '{1'b1,1'b0,4'd2,32'h404,8'd0,3'd0,2'd1,4'd0,2'd0,1'b1,8'd9},
    '{1'b1,1'b1,4'd1,32'h400,8'd0,3'd3,2'd1,4'd0,2'd0,1'b0,8'd8},  // R8 killed
    '{1'b0,1'b1,4'd3,32'h500,8'd2,3'd0,2'd1,4'd0,2'd0,1'b0,8'd3},  // R3 3 bytes
    '{1'b1,1'b1,4'd3,32'h500,8'd2,3'd0,2'd1,4'd0,2'd0,1'b1,8'd9},  // R9 bad locked
    '{1'b0,1'b1,4'd3,32'h500,8'd0,3'd7,2'd1,4'd0,2'd1,1'b0,8'd3},  // R3 128 bytes
    '{1'b0,1'b1,4'd4,32'h600,8'd1,3'd7,2'd1,4'd0,2'd0,1'b0,8'd3},  // R3 256 bytes
    '{1'b0,1'b1,4'd4,32'h604,8'd0,3'd3,2'd1,4'd0,2'd0,1'b0,8'd4},  // R4 misaligned
    '{1'b0,1'b1,4'd4,32'h608,8'd0,3'd3,2'd1,4'd2,2'd0,1'b0,8'd5},  // R5 cacheable
    '{1'b0,1'b1,4'd4,32'h608,8'd0,3'd3,2'd1,4'd0,2'd1,1'b0,8'd2},
    '{1'b1,1'b1,4'd4,32'h608,8'd0,3'd2,2'd1,4'd0,2'd0,1'b0,8'd7},  // R7 size
    '{1'b1,1'b1,4'd5,32'h608,8'd0,3'd3,2'd1,4'd0,2'd0,1'b0,8'd7},  // R7 id
    '{1'b1,1'b1,4'd4,32'h608,8'd0,3'd3,2'd0,4'd0,2'd0,1'b0,8'd7},  // R7 burst
    '{1'b1,1'b1,4'd4,32'h608,8'd0,3'd3,2'd1,4'd0,2'd1,1'b1,8'd7},  // R7 slot kept
    '{1'b0,1'b1,4'd6,32'h700,8'd0,3'd2,2'd1,4'd0,2'd1,1'b0,8'd10},
    '{1'b0,1'b1,4'd6,32'h780,8'd0,3'd2,2'd1,4'd0,2'd1,1'b0,8'd10},
    '{1'b1,1'b1,4'd6,32'h700,8'd0,3'd2,2'd1,4'd0,2'd0,1'b0,8'd10}, // R10 replaced
    '{1'b1,1'b1,4'd6,32'h780,8'd0,3'd2,2'd1,4'd0,2'd1,1'b1,8'd10},
    '{1'b0,1'b0,4'd7,32'h800,8'd0,3'd2,2'd1,4'd0,2'd0,1'b0,8'd12}, // R12 plain read
    '{1'b1,1'b1,4'd7,32'h800,8'd0,3'd2,2'd1,4'd0,2'd0,1'b0,8'd12},
    '{1'b1,1'b0,4'd2,32'h57F,8'd0,3'd0,2'd1,4'd0,2'd0,1'b1,8'd8},
    '{1'b1,1'b1,4'd3,32'h500,8'd0,3'd7,2'd1,4'd0,2'd0,1'b0,8'd8}   // R8 last byte
  };

  task automatic chk(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    if (v.isw) begin
      aw_fire = 1; aw_lock = v.lock; aw_id = v.id; aw_addr = v.addr;
      aw_len = v.len; aw_size = v.size; aw_burst = v.burst; aw_cache = v.cache;
    end else begin
      ar_fire = 1; ar_lock = v.lock; ar_id = v.id; ar_addr = v.addr;
      ar_len = v.len; ar_size = v.size; ar_burst = v.burst; ar_cache = v.cache;
    end
  endtask

  task automatic idle();
    ar_fire = 0; aw_fire = 0;
  endtask

  function automatic vec_t mk(input logic isw, input logic lock, input logic [3:0] id,
                              input logic [31:0] addr, input logic [2:0] size);
    vec_t v;
    v = '0;
    v.isw = isw; v.lock = lock; v.id = id; v.addr = addr; v.size = size; v.burst = 2'd1;
    return v;
  endfunction

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "rd_resp_valid", {3'd0, rd_resp_valid}, 4'd0);
    chk(1, "wr_resp_valid", {3'd0, wr_resp_valid}, 4'd0);
    chk(1, "wr_en", {3'd0, wr_en}, 4'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      idle();
      if (VEC[i].isw) begin
        chk(int'(VEC[i].req), "wr_resp", {2'd0, wr_resp}, {2'd0, VEC[i].resp});
        chk(int'(VEC[i].req), "wr_en", {3'd0, wr_en}, {3'd0, VEC[i].en});
      end else begin
        chk(int'(VEC[i].req), "rd_resp", {2'd0, rd_resp}, {2'd0, VEC[i].resp});
        chk(int'(VEC[i].req), "rd_resp_valid", {3'd0, rd_resp_valid}, 4'd1);
      end
    end

    // R11: reservation recorded alongside an overlapping committed write
    drive(mk(1'b0, 1'b1, 4'd2, 32'hA00, 3'd2));
    drive(mk(1'b1, 1'b0, 4'd3, 32'hA00, 3'd2));
    @(negedge clk);
    idle();
    chk(11, "rd_resp", {2'd0, rd_resp}, 4'd1);
    chk(11, "wr_en", {3'd0, wr_en}, 4'd1);
    drive(mk(1'b1, 1'b1, 4'd2, 32'hA00, 3'd2));
    @(negedge clk);
    idle();
    chk(11, "wr_resp", {2'd0, wr_resp}, 4'd1);

    // R1: reset drops reservations
    drive(mk(1'b0, 1'b1, 4'd1, 32'h900, 3'd2));
    @(negedge clk);
    idle();
    chk(1, "rd_resp before reset", {2'd0, rd_resp}, 4'd1);
    rst_n = 0;
    @(negedge clk);
    chk(1, "rd_resp_valid in reset", {3'd0, rd_resp_valid}, 4'd0);
    rst_n = 1;
    @(negedge clk);
    drive(mk(1'b1, 1'b1, 4'd1, 32'h900, 3'd2));
    @(negedge clk);
    idle();
    chk(1, "wr_resp after reset", {2'd0, wr_resp}, 4'd0);
    chk(1, "wr_en after reset", {3'd0, wr_en}, 4'd0);
    @(negedge clk);
    chk(1, "wr_en idle", {3'd0, wr_en}, 4'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule